// File: doc/BRIEF.md
# Shared Memory Bus Arbiter with Atomic Lock

This block lets several requesting cores share one single-port memory. Each core offers one read or write at a time and keeps its request, direction, address and write data steady until it sees its done pulse. The arbiter grants the bus to one core. The memory access then takes a fixed number of cycles. No other core can reach the memory until that access has finished, so a plain write is never seen half done.

A core may also raise its lock input with a read. The bus then stays with that core after the read ends, and the core's next transaction, normally the write of a read-modify-write, follows with no other access in between. The lock ends on the cycle that the locked write completes. If the owner drops both lock and request without writing, the lock also ends. A fetch-and-add is built from this: a locked read returns the old value, and a locked write stores old plus operand. When unlocked transactions compete, arbitration is round-robin.

Top module: `busl_arbiter`

## Requirements
- R1: During reset and on the first cycle after it, every grant bit and every done bit is 0.
- R2: At most one grant bit is set in any cycle. A done bit is set only for the core that held the grant in the previous cycle.
- R3: An unlocked transaction takes LAT cycles. The grant rises one cycle after the request is seen. Done rises LAT cycles after the grant, and the grant drops in that same cycle. The memory is accessed once per transaction.
- R4: A read returns the data most recently written to that address.
- R5: Among cores requesting at the same time, the next grant goes to the first requester found by counting upward from the last granted core, wrapping from N-1 to 0. After reset the search starts at core 0.
- R6: Once a core's locked read completes, its grant stays set, and no other core is granted until the lock ends.
- R7: When a locked write completes, the grant drops together with done. The next grant appears one cycle later.
- R8: With N cores each performing K locked read-then-write increments of one counter that starts at 0, the final value is N*K. The old values returned are exactly 0 to N*K-1, so they sum to (N*K)(N*K-1)/2.
- R9: If the owner of a held lock drops both lock and request without writing, the lock ends. The grant is 0 on the next cycle, and a waiting core is granted one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | N | Per-core transaction request, held until done |
| core_we | input | N | Per-core direction, 1 = write |
| core_lock | input | N | Per-core lock request, keeps the bus after a read |
| core_addr | input | N*AW | Per-core word address, core i at bits i*AW |
| core_wdata | input | N*DW | Per-core write data, core i at bits i*DW |
| core_gnt | output | N | One-hot bus grant |
| core_done | output | N | One-cycle pulse when the core's transaction ends |
| core_rdata | output | N*DW | Read data per core, valid with its done pulse |

## Verification
The key collision is the completion of a locked write while other cores are already waiting to request. Here the lock release and the next round-robin decision could fall into the same cycle. The bench provokes this by having three cores request in the same cycle as a locked read-modify-write, and by running fetch-and-add loops on all cores at once. It then judges the result in two ways. First, it checks that the grant is 0 in the done cycle and goes to the next core one cycle later. Second, it checks that the shared counter ends at exactly N*K, with the returned old values forming a gap-free sequence.

// File: rtl/busl_pkg.sv
package busl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } arb_state_e;
endpackage

// File: rtl/busl_rr_pick.sv
module busl_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    int c;
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last) + k) % N;
      if (!any && req[c]) begin
        any    = 1'b1;
        gnt[c] = 1'b1;
        idx    = IW'(c);
      end
    end
  end

  // R5
  pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R5
  pick_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0 && (any == (req != '0)));
endmodule

// File: rtl/busl_req_mux.sv
module busl_req_mux #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic [IW-1:0]   sel,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    we,
  input  logic [N-1:0]    lock,
  input  logic [N*AW-1:0] addr,
  input  logic [N*DW-1:0] wdata,
  output logic            s_req,
  output logic            s_we,
  output logic            s_lock,
  output logic [AW-1:0]   s_addr,
  output logic [DW-1:0]   s_wdata
);
  logic [AW-1:0] addr_a  [N];
  logic [DW-1:0] wdata_a [N];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign addr_a[i]  = addr[i*AW +: AW];
    assign wdata_a[i] = wdata[i*DW +: DW];
  end

  always_comb begin
    s_req   = 1'b0;
    s_we    = 1'b0;
    s_lock  = 1'b0;
    s_addr  = '0;
    s_wdata = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == IW'(i)) begin
        s_req   = req[i];
        s_we    = we[i];
        s_lock  = lock[i];
        s_addr  = addr_a[i];
        s_wdata = wdata_a[i];
      end
    end
  end
endmodule

// File: rtl/busl_mem.sv
module busl_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) ram[addr] <= wdata;
      else    q         <= ram[addr];
    end
  end

  // R3
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> !en);
endmodule

// File: rtl/busl_arbiter.sv
module busl_arbiter #(
  parameter int N   = 4,
  parameter int AW  = 6,
  parameter int DW  = 16,
  parameter int LAT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    core_req,
  input  logic [N-1:0]    core_we,
  input  logic [N-1:0]    core_lock,
  input  logic [N*AW-1:0] core_addr,
  input  logic [N*DW-1:0] core_wdata,
  output logic [N-1:0]    core_gnt,
  output logic [N-1:0]    core_done,
  output logic [N*DW-1:0] core_rdata
);
  import busl_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = (LAT > 1) ? $clog2(LAT + 1) : 1;
  localparam logic [CW-1:0] CNT_START = CW'(LAT - 1);

  arb_state_e    state_q;
  logic [IW-1:0] owner_q, last_q;
  logic          locked_q;
  logic [CW-1:0] cnt_q;
  logic [N-1:0]  gnt_q, done_q;
  logic          tx_we_q;
  logic [AW-1:0] tx_addr_q;
  logic [DW-1:0] tx_wdata_q;

  logic [N-1:0]  pick_gnt;
  logic [IW-1:0] pick_idx;
  logic          pick_any;
  logic [IW-1:0] mux_sel;
  logic          s_req, s_we, s_lock;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic          mem_en;
  logic [DW-1:0] mem_q;

  busl_rr_pick #(.N(N), .IW(IW)) u_pick (
    .clk(clk), .rst(rst), .req(core_req), .last(last_q),
    .gnt(pick_gnt), .idx(pick_idx), .any(pick_any)
  );

  assign mux_sel = (state_q == ST_IDLE) ? pick_idx : owner_q;

  busl_req_mux #(.N(N), .IW(IW), .AW(AW), .DW(DW)) u_mux (
    .sel(mux_sel), .req(core_req), .we(core_we), .lock(core_lock),
    .addr(core_addr), .wdata(core_wdata),
    .s_req(s_req), .s_we(s_we), .s_lock(s_lock),
    .s_addr(s_addr), .s_wdata(s_wdata)
  );

  assign mem_en = (state_q == ST_BUSY) && (cnt_q == '0);

  busl_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst), .en(mem_en), .we(tx_we_q),
    .addr(tx_addr_q), .wdata(tx_wdata_q), .q(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      owner_q    <= '0;
      last_q     <= IW'(N - 1);
      locked_q   <= 1'b0;
      cnt_q      <= '0;
      gnt_q      <= '0;
      done_q     <= '0;
      tx_we_q    <= 1'b0;
      tx_addr_q  <= '0;
      tx_wdata_q <= '0;
    end else begin
      done_q <= '0;
      case (state_q)
        ST_IDLE: begin
          if (pick_any) begin
            owner_q    <= pick_idx;
            last_q     <= pick_idx;
            gnt_q      <= pick_gnt;
            locked_q   <= s_lock;
            tx_we_q    <= s_we;
            tx_addr_q  <= s_addr;
            tx_wdata_q <= s_wdata;
            cnt_q      <= CNT_START;
            state_q    <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            done_q <= gnt_q;
            if (locked_q && !tx_we_q) begin
              state_q <= ST_HOLD;
            end else begin
              locked_q <= 1'b0;
              gnt_q    <= '0;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (s_req) begin
            tx_we_q    <= s_we;
            tx_addr_q  <= s_addr;
            tx_wdata_q <= s_wdata;
            cnt_q      <= CNT_START;
            state_q    <= ST_BUSY;
          end else if (!s_lock) begin
            locked_q <= 1'b0;
            gnt_q    <= '0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign core_gnt  = gnt_q;
  assign core_done = done_q;

  for (genvar i = 0; i < N; i++) begin : g_rdata
    assign core_rdata[i*DW +: DW] = mem_q;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (core_gnt == '0 && core_done == '0));

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_gnt));

  // R2
  done_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (core_done != '0) |-> (core_done == $past(core_gnt)));

  // R6
  lock_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_q && state_q != ST_IDLE) |=>
      (core_gnt == $past(core_gnt) || core_gnt == '0));
endmodule

// File: tb/tb_busl_arbiter.sv
`timescale 1ns/1ps
module tb_busl_arbiter;
  localparam int N   = 4;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int LAT = 3;
  localparam int K   = 5;
  localparam int WD  = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          b_req   [N];
  logic          b_we    [N];
  logic          b_lock  [N];
  logic [AW-1:0] b_addr  [N];
  logic [DW-1:0] b_wdata [N];

  logic [N-1:0]    core_req, core_we, core_lock, core_gnt, core_done;
  logic [N*AW-1:0] core_addr;
  logic [N*DW-1:0] core_wdata, core_rdata;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      core_req[i]             = b_req[i];
      core_we[i]              = b_we[i];
      core_lock[i]            = b_lock[i];
      core_addr[i*AW +: AW]   = b_addr[i];
      core_wdata[i*DW +: DW]  = b_wdata[i];
    end
  end

  busl_arbiter #(.N(N), .AW(AW), .DW(DW), .LAT(LAT)) dut (
    .clk(clk), .rst(rst), .core_req(core_req), .core_we(core_we),
    .core_lock(core_lock), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_gnt(core_gnt), .core_done(core_done), .core_rdata(core_rdata)
  );

  int checks = 0;
  int errors = 0;
  int mon_err = 0;
  logic [N-1:0] gnt_prev = '0;
  int ord [N];
  int ord_n;
  int old_sum;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 monitor: one-hot grant, done only for previous grant holder
  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(core_gnt) > 1) mon_err++;
      if (core_done != '0 && core_done != gnt_prev) mon_err++;
    end
    gnt_prev = core_gnt;
  end

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < N; i++) begin
      b_req[i] = 0; b_we[i] = 0; b_lock[i] = 0; b_addr[i] = '0; b_wdata[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic txn(input int c, input bit w, input bit lk, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, output logic [DW-1:0] q);
    b_req[c] = 1'b1; b_we[c] = w; b_lock[c] = lk; b_addr[c] = a; b_wdata[c] = d;
    do @(negedge clk); while (!core_done[c]);
    q = core_rdata[c*DW +: DW];
    b_req[c] = 1'b0;
  endtask

  task automatic faa(input int c, input logic [AW-1:0] a, input logic [DW-1:0] inc,
                     output logic [DW-1:0] old);
    logic [DW-1:0] dummy;
    txn(c, 1'b0, 1'b1, a, '0, old);
    txn(c, 1'b1, 1'b1, a, old + inc, dummy);
    b_lock[c] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(core_gnt == '0, "R1 gnt after reset", core_gnt, 0);
    check(core_done == '0, "R1 done after reset", core_done, 0);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] q;
    txn(1, 1'b1, 1'b0, 6'd5, 16'h1234, q);
    txn(3, 1'b1, 1'b0, 6'd6, 16'hBEEF, q);
    txn(0, 1'b0, 1'b0, 6'd5, '0, q);
    check(q == 16'h1234, "R4 read addr5", q, 16'h1234);
    txn(2, 1'b0, 1'b0, 6'd6, '0, q);
    check(q == 16'hBEEF, "R4 read addr6", q, 16'hBEEF);
  endtask

  task automatic t_latency();
    int n = 0;
    b_req[2] = 1'b1; b_we[2] = 1'b0; b_lock[2] = 1'b0; b_addr[2] = 6'd5;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check(core_gnt == 4'b0100, "R3 grant one cycle after request", core_gnt, 4'b0100);
    end while (!core_done[2] && n < 20);
    b_req[2] = 1'b0;
    check(n == LAT + 1, "R3 done latency", n, LAT + 1);
    check(core_gnt == '0, "R3 grant drops with done", core_gnt, 0);
  endtask

  task automatic rr_core(input int c);
    logic [DW-1:0] q;
    txn(c, 1'b0, 1'b0, 6'd1, '0, q);
    ord[ord_n] = c;
    ord_n++;
  endtask

  task automatic t_round_robin();
    logic [DW-1:0] q;
    do_reset();
    txn(2, 1'b0, 1'b0, 6'd1, '0, q);
    ord_n = 0;
    for (int i = 0; i < N; i++) begin
      automatic int c = i;
      fork rr_core(c); join_none
    end
    wait fork;
    for (int i = 0; i < N; i++)
      check(ord[i] == (3 + i) % N, "R5 round-robin order", ord[i], (3 + i) % N);
  endtask

  task automatic lock_owner();
    logic [DW-1:0] old, dummy;
    txn(1, 1'b0, 1'b1, 6'd10, '0, old);
    check(old == 16'd7, "R6 locked read value", old, 7);
    check(core_gnt == 4'b0010, "R6 grant kept after locked read", core_gnt, 4'b0010);
    txn(1, 1'b1, 1'b1, 6'd10, old + 16'd1, dummy);
    b_lock[1] = 1'b0;
    check(core_gnt == '0, "R7 grant drops with locked write done", core_gnt, 0);
    @(negedge clk);
    check(core_gnt == 4'b0100, "R7 next grant one cycle later", core_gnt, 4'b0100);
  endtask

  task automatic lock_other(input int c, input logic [DW-1:0] d);
    logic [DW-1:0] q;
    txn(c, 1'b1, 1'b0, 6'd11, d, q);
  endtask

  task automatic t_lock();
    logic [DW-1:0] q;
    do_reset();
    txn(0, 1'b1, 1'b0, 6'd10, 16'd7, q);
    fork
      lock_owner();
      lock_other(2, 16'h2222);
      lock_other(3, 16'h3333);
    join
    txn(0, 1'b0, 1'b0, 6'd10, '0, q);
    check(q == 16'd8, "R6 locked update result", q, 8);
    txn(0, 1'b0, 1'b0, 6'd11, '0, q);
    check(q == 16'h3333, "R5 later writer wins", q, 16'h3333);
  endtask

  task automatic t_release();
    logic [DW-1:0] q;
    do_reset();
    txn(0, 1'b0, 1'b1, 6'd3, '0, q);
    b_req[3] = 1'b1; b_we[3] = 1'b0; b_lock[3] = 1'b0; b_addr[3] = 6'd3;
    b_lock[0] = 1'b0;
    @(negedge clk);
    check(core_gnt == '0, "R9 grant released on dropped lock", core_gnt, 0);
    @(negedge clk);
    check(core_gnt == 4'b1000, "R9 waiting core granted", core_gnt, 4'b1000);
    do @(negedge clk); while (!core_done[3]);
    b_req[3] = 1'b0;
  endtask

  task automatic faa_core(input int c);
    logic [DW-1:0] old;
    for (int r = 0; r < K; r++) begin
      faa(c, 6'd20, 16'd1, old);
      old_sum += int'(old);
    end
  endtask

  task automatic t_fetch_add();
    logic [DW-1:0] q;
    do_reset();
    txn(0, 1'b1, 1'b0, 6'd20, 16'd0, q);
    old_sum = 0;
    for (int i = 0; i < N; i++) begin
      automatic int c = i;
      fork faa_core(c); join_none
    end
    wait fork;
    txn(2, 1'b0, 1'b0, 6'd20, '0, q);
    check(q == 16'(N * K), "R8 final counter", q, N * K);
    check(old_sum == (N * K) * (N * K - 1) / 2, "R8 old value sum", old_sum,
          (N * K) * (N * K - 1) / 2);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      b_req[i] = 0; b_we[i] = 0; b_lock[i] = 0; b_addr[i] = '0; b_wdata[i] = '0;
    end
    @(negedge clk);
    t_reset();
    t_write_read();
    t_latency();
    t_round_robin();
    t_lock();
    t_release();
    t_fetch_add();
    check(mon_err == 0, "R2 grant and done monitor", mon_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule